// File: doc/BRIEF.md
# Oversampling asynchronous serial receiver

This block recovers characters from a single asynchronous serial input line. A one-cycle enable pulse, the base tick, is supplied from outside at either 16 or 8 times the bit rate. A mode input selects which of the two ratios is in use. The input line first passes through a two-flop synchroniser. The receiver watches the synchronised line at every base tick for a high-to-low transition, which marks the start bit. It then counts ticks from that point and takes each bit at its nominal centre.

A character carries 7 or 8 data bits, least significant bit first. An optional even or odd parity bit may follow the data, then at least one stop bit. The block checks only the first stop bit. After that sample it rearms at once, so a second stop bit is simply idle line. The character and its error flags appear together with a one-cycle valid strobe.

The format settings are captured when the start edge is detected. They may therefore change freely while a frame is in flight.

Top module: `osrx_receiver`

## Requirements
- R1: After reset, rx_valid, rx_perr and rx_ferr are 0 and rx_data is all zeros.
- R2: The line is synchronised by two flops. A start is taken only at a base tick where the synchronised line is low and was high at the previous base tick. A line held low produces no further frames after the first.
- R3: With osr_sel8 = 0, the start bit is sampled at the 8th base tick after the tick that saw the falling edge. Every following bit is sampled 16 ticks after the previous one.
- R4: With osr_sel8 = 1, the start bit is sampled at the 4th base tick after the edge tick. Every following bit is sampled 8 ticks after the previous one.
- R5: If the start bit is high at its centre sample, the receiver returns to idle and reports nothing.
- R6: Data bits arrive least significant bit first. With len_short = 1 seven bits are taken and rx_data[7] reads 0; with len_short = 0 eight bits are taken.
- R7: With par_en = 1, one parity bit follows the data. rx_perr is 1 when the data bits plus the parity bit hold an odd count of ones (par_odd = 0) or an even count of ones (par_odd = 1). With par_en = 0, no parity bit is expected and rx_perr stays 0.
- R8: If the first stop bit samples low, rx_ferr is 1 for that frame, and the data is still delivered.
- R9: rx_valid is high for exactly one clock, starting in the clock after the first stop bit's sample tick. rx_data and the flags hold their values until the next frame is reported.
- R10: The mode, length and parity inputs are captured at start detection. Changing them during a frame does not affect that frame.
- R11: The receiver rearms right after the first stop sample. A start bit that directly follows a single stop bit is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle enable at 16x or 8x the bit rate |
| osr_sel8 | input | 1 | 1 selects 8x oversampling, 0 selects 16x |
| len_short | input | 1 | 1 selects seven data bits, 0 selects eight |
| par_en | input | 1 | 1 expects a parity bit after the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rx_data | output | 8 | Received character, right aligned |
| rx_valid | output | 1 | One-cycle strobe marking a new character |
| rx_perr | output | 1 | Parity error for the reported character |
| rx_ferr | output | 1 | Framing error for the reported character |

## Verification
The hardest cases to reach are the exact sample instant and a configuration change inside a frame.

To check the sample instant, the bench aligns each start edge to a known tick phase. It then predicts the exact clock count from the start edge to the valid strobe, for both ratios and every frame length. A one-tick slip in the sample counter therefore shows up as a timing error even when the data happens to come through intact.

To check configuration capture, the bench runs a second thread in parallel with a 16x frame. That thread flips the ratio and parity inputs partway through the frame, and the result must still match the original format. Short low pulses and a long held-low line cover glitch rejection and the break case.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_START,
      S_DATA,
      S_PAR,
      S_STOP
   } rx_state_e;

   typedef struct packed {
      logic x8;
      logic short_len;
      logic par_en;
      logic par_odd;
   } rx_cfg_t;

endpackage

// File: rtl/osrx_sync.sv
module osrx_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("osrx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_VAL}};
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/osrx_ctrl.sv
module osrx_ctrl
   import osrx_pkg::*;
#(
   parameter int DATA_MAX = 8,
   parameter int OSR_HI   = 16,
   parameter int OSR_LO   = 8,
   parameter bit LO_EN    = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    rxd_s,
   input  rx_cfg_t cfg_in,
   output rx_cfg_t cfg,
   output logic    clr,
   output logic    shift_en,
   output logic    par_smp,
   output logic    done
);

   localparam int CW = $clog2(OSR_HI);
   localparam int IW = $clog2(DATA_MAX);
   localparam logic [CW-1:0] HI_FULL = CW'(OSR_HI - 1);
   localparam logic [CW-1:0] HI_HALF = CW'(OSR_HI / 2 - 1);
   localparam logic [CW-1:0] LO_FULL = CW'(OSR_LO - 1);
   localparam logic [CW-1:0] LO_HALF = CW'(OSR_LO / 2 - 1);

   if (OSR_LO < 2 || (OSR_LO % 2) != 0 || (OSR_HI % 2) != 0 || OSR_HI <= OSR_LO) begin : g_bad_osr
      $error("osrx_ctrl: ratios must be even with OSR_HI > OSR_LO >= 2");
   end

   rx_state_e      state;
   logic [CW-1:0]  cnt;
   logic [IW-1:0]  idx;
   logic           prev_s;
   logic [CW-1:0]  full_m1, half_m1, target;
   logic [IW-1:0]  last_idx;
   logic           hit;

   if (LO_EN) begin : g_dual
      assign full_m1 = cfg.x8 ? LO_FULL : HI_FULL;
      assign half_m1 = cfg.x8 ? LO_HALF : HI_HALF;
   end else begin : g_single
      assign full_m1 = HI_FULL;
      assign half_m1 = HI_HALF;
   end

   assign target   = (state == S_START) ? half_m1 : full_m1;
   assign last_idx = cfg.short_len ? IW'(DATA_MAX - 2) : IW'(DATA_MAX - 1);
   assign clr      = (state == S_IDLE) && tick && prev_s && !rxd_s;
   assign hit      = (state != S_IDLE) && tick && (cnt == target);
   assign shift_en = hit && (state == S_DATA);
   assign par_smp  = hit && (state == S_PAR);
   assign done     = hit && (state == S_STOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         cnt    <= '0;
         idx    <= '0;
         prev_s <= 1'b1;
         cfg    <= '0;
      end else begin
         if (tick) prev_s <= rxd_s;
         if (state == S_IDLE) begin
            if (clr) begin
               state <= S_START;
               cnt   <= '0;
               cfg   <= cfg_in;
            end
         end else if (tick) begin
            if (cnt == target) begin
               cnt <= '0;
               case (state)
                  S_START: begin
                     if (rxd_s) state <= S_IDLE;
                     else begin
                        state <= S_DATA;
                        idx   <= '0;
                     end
                  end
                  S_DATA: begin
                     idx <= idx + 1'b1;
                     if (idx == last_idx) state <= cfg.par_en ? S_PAR : S_STOP;
                  end
                  S_PAR:   state <= S_STOP;
                  default: state <= S_IDLE;
               endcase
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE) |-> (cnt <= full_m1)); // R3
   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(cfg)); // R10
   AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_START && tick && cnt == half_m1 && rxd_s) |=> (state == S_IDLE)); // R5
   AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_IDLE && !(tick && prev_s && !rxd_s)) |=> (state == S_IDLE)); // R2

endmodule

// File: rtl/osrx_frame.sv
module osrx_frame #(
   parameter int DATA_MAX = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                shift_en,
   input  logic                par_smp,
   input  logic                done,
   input  logic                bit_in,
   input  logic                short_len,
   input  logic                par_en,
   input  logic                par_odd,
   output logic [DATA_MAX-1:0] rx_data,
   output logic                rx_valid,
   output logic                rx_perr,
   output logic                rx_ferr
);

   logic [DATA_MAX-1:0] sreg;
   logic                acc;
   logic [DATA_MAX-1:0] aligned;

   assign aligned = short_len ? {1'b0, sreg[DATA_MAX-1:1]} : sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg     <= '0;
         acc      <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         rx_perr  <= 1'b0;
         rx_ferr  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (clr) acc <= 1'b0;
         else if (shift_en || par_smp) acc <= acc ^ bit_in;
         if (shift_en) sreg <= {bit_in, sreg[DATA_MAX-1:1]};
         if (done) begin
            rx_data  <= aligned;
            rx_valid <= 1'b1;
            rx_perr  <= par_en & (acc ^ par_odd);
            rx_ferr  <= ~bit_in;
         end
      end
   end

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R9
   AST_SHORT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && short_len) |-> !rx_data[DATA_MAX-1]); // R6
   AST_NOPAR_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !par_en) |-> !rx_perr); // R7

endmodule

// File: rtl/osrx_receiver.sv
module osrx_receiver
   import osrx_pkg::*;
#(
   parameter int DATA_MAX    = 8,
   parameter int OSR_HI      = 16,
   parameter int OSR_LO      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit LO_EN       = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                base_tick,
   input  logic                osr_sel8,
   input  logic                len_short,
   input  logic                par_en,
   input  logic                par_odd,
   input  logic                rxd,
   output logic [DATA_MAX-1:0] rx_data,
   output logic                rx_valid,
   output logic                rx_perr,
   output logic                rx_ferr
);

   if (DATA_MAX < 2 || DATA_MAX > 16) begin : g_bad_len
      $error("osrx_receiver: DATA_MAX out of range");
   end

   logic    rxd_s;
   rx_cfg_t cfg_in, cfg;
   logic    clr, shift_en, par_smp, done;

   assign cfg_in = '{x8: osr_sel8, short_len: len_short, par_en: par_en, par_odd: par_odd};

   osrx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (rxd),
      .q_sync  (rxd_s)
   );

   osrx_ctrl #(.DATA_MAX(DATA_MAX), .OSR_HI(OSR_HI), .OSR_LO(OSR_LO), .LO_EN(LO_EN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (base_tick),
      .rxd_s    (rxd_s),
      .cfg_in   (cfg_in),
      .cfg      (cfg),
      .clr      (clr),
      .shift_en (shift_en),
      .par_smp  (par_smp),
      .done     (done)
   );

   osrx_frame #(.DATA_MAX(DATA_MAX)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .shift_en  (shift_en),
      .par_smp   (par_smp),
      .done      (done),
      .bit_in    (rxd_s),
      .short_len (cfg.short_len),
      .par_en    (cfg.par_en),
      .par_odd   (cfg.par_odd),
      .rx_data   (rx_data),
      .rx_valid  (rx_valid),
      .rx_perr   (rx_perr),
      .rx_ferr   (rx_ferr)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rx_valid); // R1

endmodule

// File: tb/sim_osrx_receiver.sv
module sim_osrx_receiver;

   localparam int TP = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       base_tick;
   logic       osr_sel8 = 1'b0, len_short = 1'b0, par_en = 1'b0, par_odd = 1'b0;
   logic       rxd = 1'b1;
   logic [7:0] rx_data;
   logic       rx_valid, rx_perr, rx_ferr;

   int  checks = 0, errors = 0;
   int  tph = 0;
   int  cyc = 0;
   int  vcount = 0;
   int  cap_cyc = 0;
   int  t_start = 0;
   logic [7:0] cap_data;
   logic cap_perr, cap_ferr, last_v = 1'b0;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   always @(negedge clk) tph <= (tph == TP - 1) ? 0 : tph + 1;
   assign base_tick = (tph == 0);
   always @(posedge clk) cyc <= cyc + 1;

   osrx_receiver u0 (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .osr_sel8(osr_sel8),
      .len_short(len_short), .par_en(par_en), .par_odd(par_odd), .rxd(rxd),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: capture strobes, check they last one clock (R9)
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            vcount++;
            cap_cyc  = cyc;
            cap_data = rx_data;
            cap_perr = rx_perr;
            cap_ferr = rx_ferr;
            if (last_v) chk(1'b0, "R9 strobe width", 2, 1);
         end
         last_v = rx_valid;
      end
   end

   function automatic logic par_bit(input logic [7:0] d, input bit odd);
      return (^d) ^ odd;
   endfunction

   task automatic align_start();
      @(negedge clk);
      while (tph != TP - 1) @(negedge clk);
      rxd = 1'b0;
      t_start = cyc;
   endtask

   task automatic send_frame(input logic [7:0] d, input bit x8, input bit sh, input bit pe,
                             input bit po, input int nstop, input bit bad_par, input bit bad_stop);
      int bt;
      logic [7:0] dm;
      bt = (x8 ? 8 : 16) * TP;
      dm = sh ? (d & 8'h7f) : d;
      osr_sel8 = x8; len_short = sh; par_en = pe; par_odd = po;
      align_start();
      repeat (bt) @(negedge clk);
      for (int i = 0; i < (sh ? 7 : 8); i++) begin
         rxd = d[i];
         repeat (bt) @(negedge clk);
      end
      if (pe) begin
         rxd = par_bit(dm, po) ^ bad_par;
         repeat (bt) @(negedge clk);
      end
      rxd = bad_stop ? 1'b0 : 1'b1;
      repeat (bt) @(negedge clk);
      rxd = 1'b1;
      if (nstop == 2 || bad_stop) repeat (bt) @(negedge clk);
   endtask

   task automatic expect_frame(input string req, input int n0, input logic [7:0] d, input bit x8,
                               input bit sh, input bit pe, input bit bad_par, input bit bad_stop);
      int osr, nb, lat;
      logic [7:0] dm;
      osr = x8 ? 8 : 16;
      nb  = (sh ? 7 : 8) + (pe ? 1 : 0) + 1;
      lat = 5 + TP * (osr / 2 + nb * osr);
      dm  = sh ? (d & 8'h7f) : d;
      chk(vcount == n0 + 1, {req, " frame count"}, vcount - n0, 1);
      chk(cap_data == dm, {req, " data"}, cap_data, dm);
      chk(cap_perr == (pe & bad_par), {req, " parity flag"}, cap_perr, pe & bad_par);
      chk(cap_ferr == bad_stop, {req, " framing flag"}, cap_ferr, bad_stop);
      chk(cap_cyc - t_start == lat, {req, " sample timing"}, cap_cyc - t_start, lat);
   endtask

   task automatic run_frame(input string req, input logic [7:0] d, input bit x8, input bit sh,
                            input bit pe, input bit po, input int nstop, input bit bad_par,
                            input bit bad_stop);
      int n0 = vcount;
      send_frame(d, x8, sh, pe, po, nstop, bad_par, bad_stop);
      expect_frame(req, n0, d, x8, sh, pe, bad_par, bad_stop);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int n0;
      void'($urandom(32'h1f2e3d4c));
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(rx_valid == 0 && rx_perr == 0 && rx_ferr == 0 && rx_data == 0, "R1 reset outputs",
          {rx_valid, rx_perr, rx_ferr, rx_data}, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);

      // R3, R4: exact sample instants, both ratios
      run_frame("R3 16x 8N1", 8'ha5, 0, 0, 0, 0, 1, 0, 0);
      run_frame("R4 8x 8N1", 8'h3c, 1, 0, 0, 0, 1, 0, 0);
      // R6: seven-bit frames, MSB of line data ignored
      run_frame("R6 7-bit", 8'hd3, 0, 1, 0, 0, 1, 0, 0);
      run_frame("R6 8-bit lsb first", 8'h01, 1, 0, 0, 0, 2, 0, 0);
      // R7: parity modes and errors
      run_frame("R7 even ok", 8'h17, 0, 0, 1, 0, 1, 0, 0);
      run_frame("R7 odd ok", 8'h17, 1, 1, 1, 1, 2, 0, 0);
      run_frame("R7 even bad", 8'h80, 0, 0, 1, 0, 1, 1, 0);
      run_frame("R7 odd bad", 8'h00, 1, 0, 1, 1, 1, 1, 0);
      // R8: framing error with data kept
      run_frame("R8 bad stop", 8'h5a, 0, 0, 1, 1, 1, 0, 1);
      // R11: back-to-back with single stop
      run_frame("R11 first", 8'hf0, 0, 0, 0, 0, 1, 0, 0);
      run_frame("R11 second", 8'h0f, 0, 0, 0, 0, 1, 0, 0);
      run_frame("R11 8x first", 8'h99, 1, 1, 1, 0, 1, 0, 0);
      run_frame("R11 8x second", 8'h66, 1, 1, 1, 0, 1, 0, 0);

      // R10: flip settings mid-frame
      n0 = vcount;
      fork
         send_frame(8'hc6, 0, 0, 1, 0, 1, 0, 0);
         begin
            repeat (300) @(negedge clk);
            osr_sel8 = 1'b1; len_short = 1'b1; par_en = 1'b0; par_odd = 1'b1;
         end
      join
      expect_frame("R10 mid-frame change", n0, 8'hc6, 0, 0, 1, 0, 0);

      // R5: start glitches in both ratios
      for (int m = 0; m < 2; m++) begin
         osr_sel8 = m[0];
         n0 = vcount;
         align_start();
         repeat (2 * TP) @(negedge clk);
         rxd = 1'b1;
         repeat (12 * 16 * TP) @(negedge clk);
         chk(vcount == n0, "R5 glitch rejected", vcount - n0, 0);
      end
      run_frame("R5 frame after glitch", 8'h42, 0, 0, 0, 0, 1, 0, 0);

      // R2: line held low gives one framing-error frame only
      osr_sel8 = 0; len_short = 0; par_en = 0;
      n0 = vcount;
      align_start();
      repeat (3 * 10 * 16 * TP) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * 16 * TP) @(negedge clk);
      chk(vcount == n0 + 1, "R2 held low single frame", vcount - n0, 1);
      chk(cap_ferr == 1 && cap_data == 0, "R2 break content", {cap_ferr, cap_data}, 9'h100);
      run_frame("R2 recovery", 8'h81, 0, 0, 0, 0, 1, 0, 0);

      // random mix (R3 R4 R6 R7 R8 R9)
      for (int k = 0; k < 40; k++) begin
         logic [7:0] d;
         bit x8, sh, pe, po, bp, bs;
         int ns;
         d  = 8'($urandom_range(0, 255));
         x8 = 1'($urandom_range(0, 1));
         sh = 1'($urandom_range(0, 1));
         pe = 1'($urandom_range(0, 1));
         po = 1'($urandom_range(0, 1));
         ns = $urandom_range(1, 2);
         bp = ($urandom_range(0, 4) == 0);
         bs = ($urandom_range(0, 5) == 0);
         run_frame("R7 random", d, x8, sh, pe, po, ns, bp, bs);
      end

      repeat (10) @(negedge clk);
      chk(rx_valid == 0, "R9 strobe low when idle", rx_valid, 0);
      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule